// File: doc/BRIEF.md
# Byte-Addressable Load/Store Unit

This block sits between a processor's execute stage and a 32-bit-wide data memory that is addressed in bytes. Each cycle it may accept one request consisting of a base register value, a signed 16-bit displacement, the register value to store and a two-bit operation code. From these it forms the effective address. It then drives a word-aligned memory address, per-byte write enables and a write-data bus. For loads it returns a register-ready result one cycle later. The data memory is assumed to read synchronously.

Byte placement inside a word is set by the `BIG_ENDIAN` parameter. With `BIG_ENDIAN = 0`, the byte at offset 0 within a word occupies bits 7:0. With `BIG_ENDIAN = 1`, that byte occupies bits 31:24. Byte loads are sign-extended into the full register. Byte stores take the low register byte as it is. A word access whose address is not a multiple of four is flagged as misaligned, and it touches no memory.

The control is a two-state machine. `ST_IDLE` means no load result is owed. `ST_LOAD_RESP` means a load was issued in the previous cycle and its result is presented now. The transition into `ST_LOAD_RESP` is taken on any cycle that issues a memory read, from either state. The transition back to `ST_IDLE` is taken on any cycle in `ST_LOAD_RESP` that issues no new read. `ST_LOAD_RESP` can therefore repeat for back-to-back loads.

Top module: `lsu_top`

## Requirements
- R1: The effective address is `base + sign_extend(offset)`. `mem_addr` equals that address with bits 1:0 forced to zero, during the request cycle.
- R2: An aligned word store (`req_op` = 2'b01) raises `mem_we` with `mem_be` = 4'b1111 and `mem_wdata` equal to `store_data`.
- R3: An aligned word load (`req_op` = 2'b00) raises `mem_re`. In the following cycle, `load_valid` is high and `load_data` equals the full 32-bit memory word.
- R4: A byte load (`req_op` = 2'b10) returns the addressed byte in `load_data[7:0]`, with bits 31:8 all equal to bit 7 of that byte.
- R5: A byte store (`req_op` = 2'b11) enables exactly one `mem_be` bit. That lane of `mem_wdata` carries `store_data[7:0]`, and the other three bytes of the memory word keep their values.
- R6: With `BIG_ENDIAN = 0`, the byte lane used is k = address bits 1:0. Lane k is `mem_be[k]` and data bits 8k+7:8k.
- R7: With `BIG_ENDIAN = 1`, the byte lane used is k = 3 − (address bits 1:0). Address offset 0 therefore maps to bits 31:24 and `mem_be[3]`.
- R8: A word access with nonzero address bits 1:0 raises `misaligned` in the request cycle. It raises neither `mem_we` nor `mem_re`, it leaves memory unchanged, and no `load_valid` follows.
- R9: During reset, and in any cycle without a request, `mem_we`, `mem_re` and `mem_be` are zero. `load_valid` is low unless a load was issued in the previous cycle.
- R10: Loads issued in consecutive cycles each return their own result exactly one cycle after issue, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 00 word load, 01 word store, 10 byte load, 11 byte store |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Register value to store |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables, bit k for data bits 8k+7:8k |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after `mem_re` |
| load_valid | output | 1 | `load_data` holds a load result |
| load_data | output | 32 | Register-aligned load result |
| misaligned | output | 1 | Current request is a misaligned word access |

## Verification
The bench runs one little-endian and one big-endian instance side by side on identical requests. A lane mapping that ignores the parameter therefore shows up as a wrong `mem_be` or a corrupted neighbour byte in one of the two. Byte loads cover bytes with bit 7 set and bytes with bit 7 clear. A design that zero-extends, or that extends from the wrong bit, returns a wrong upper half. A negative displacement checks that the offset is sign-extended rather than zero-extended. A misaligned store is followed by a reload of the same word, and a misaligned load is followed by an idle cycle. A design that still wrote memory or still raised `load_valid` would then fail. Back-to-back byte loads across all four offsets catch a design that drops a result or answers one cycle late.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    typedef enum logic [1:0] {
        OP_LW = 2'b00,
        OP_SW = 2'b01,
        OP_LB = 2'b10,
        OP_SB = 2'b11
    } mem_op_e;

    typedef enum logic {
        ST_IDLE      = 1'b0,
        ST_LOAD_RESP = 1'b1
    } lsu_state_e;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16,
    parameter int LANE_BITS  = 2,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic [ADDR_W-1:0]    base,
    input  logic [OFF_W-1:0]     offset,
    input  logic                 is_word,
    output logic [ADDR_W-1:0]    word_addr,
    output logic [LANE_BITS-1:0] lane,
    output logic                 unaligned
);
    localparam int NUM_LANES = 1 << LANE_BITS;

    logic [ADDR_W-1:0]    eff_addr;
    logic [LANE_BITS-1:0] byte_ofs;

    always_comb begin
        eff_addr  = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        byte_ofs  = eff_addr[LANE_BITS-1:0];
        word_addr = {eff_addr[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};
        unaligned = is_word && (byte_ofs != '0);
    end

    generate
        if (BIG_ENDIAN) begin : g_big
            assign lane = LANE_BITS'(NUM_LANES - 1) - byte_ofs;
        end else begin : g_little
            assign lane = byte_ofs;
        end
    endgenerate
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]           store_data,
    input  logic [$clog2(DATA_W/8)-1:0] lane,
    input  logic                        is_byte,
    output logic [DATA_W/8-1:0]         be,
    output logic [DATA_W-1:0]           wdata
);
    localparam int NUM_LANES = DATA_W / 8;
    localparam int LANE_BITS = $clog2(NUM_LANES);

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            always_comb begin
                if (is_byte) begin
                    be[g]          = (lane == LANE_BITS'(g));
                    wdata[8*g +: 8] = store_data[7:0];
                end else begin
                    be[g]          = 1'b1;
                    wdata[8*g +: 8] = store_data[8*g +: 8];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]           rdata,
    input  logic [$clog2(DATA_W/8)-1:0] lane,
    input  logic                        is_byte,
    output logic [DATA_W-1:0]           result
);
    logic [7:0] picked;

    always_comb begin
        picked = rdata[{lane, 3'b000} +: 8];
        if (is_byte) begin
            result = {{(DATA_W-8){picked[7]}}, picked};
        end else begin
            result = rdata;
        end
    end
endmodule

// File: rtl/lsu_top.sv
module lsu_top #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int OFF_W      = 16,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W-1:0]   base,
    input  logic [OFF_W-1:0]    offset,
    input  logic [DATA_W-1:0]   store_data,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic                mem_we,
    output logic                mem_re,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                load_valid,
    output logic [DATA_W-1:0]   load_data,
    output logic                misaligned
);
    import lsu_pkg::*;

    localparam int NUM_LANES = DATA_W / 8;
    localparam int LANE_BITS = $clog2(NUM_LANES);

    mem_op_e              op;
    logic                 is_word;
    logic                 is_byte;
    logic                 is_load;
    logic                 is_store;
    logic                 unaligned;
    logic                 access_ok;
    logic [LANE_BITS-1:0] lane;
    logic [NUM_LANES-1:0] be_raw;
    logic [DATA_W-1:0]    wdata_raw;

    lsu_state_e           state_q;
    lsu_state_e           state_d;
    logic [LANE_BITS-1:0] lane_q;
    logic                 byte_q;

    always_comb begin
        op       = mem_op_e'(req_op);
        is_word  = (op == OP_LW) || (op == OP_SW);
        is_byte  = !is_word;
        is_load  = (op == OP_LW) || (op == OP_LB);
        is_store = !is_load;
    end

    lsu_addr_gen #(
        .ADDR_W    (ADDR_W),
        .OFF_W     (OFF_W),
        .LANE_BITS (LANE_BITS),
        .BIG_ENDIAN(BIG_ENDIAN)
    ) i_addr_gen (
        .base     (base),
        .offset   (offset),
        .is_word  (is_word),
        .word_addr(mem_addr),
        .lane     (lane),
        .unaligned(unaligned)
    );

    lsu_store_lanes #(
        .DATA_W(DATA_W)
    ) i_store_lanes (
        .store_data(store_data),
        .lane      (lane),
        .is_byte   (is_byte),
        .be        (be_raw),
        .wdata     (wdata_raw)
    );

    lsu_load_align #(
        .DATA_W(DATA_W)
    ) i_load_align (
        .rdata  (mem_rdata),
        .lane   (lane_q),
        .is_byte(byte_q),
        .result (load_data)
    );

    // request-side strobes
    always_comb begin
        misaligned = req_valid && unaligned;
        access_ok  = req_valid && !unaligned;
        mem_we     = access_ok && is_store;
        mem_re     = access_ok && is_load;
        mem_be     = access_ok ? be_raw : '0;
        mem_wdata  = wdata_raw;
    end

    // state register and captured load attributes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lane_q  <= '0;
            byte_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (mem_re) begin
                lane_q <= lane;
                byte_q <= is_byte;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      state_d = mem_re ? ST_LOAD_RESP : ST_IDLE;
            ST_LOAD_RESP: state_d = mem_re ? ST_LOAD_RESP : ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        load_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:      load_valid = 1'b0;
            ST_LOAD_RESP: load_valid = 1'b1;
            default:      load_valid = 1'b0;
        endcase
    end

    // R8
    misaligned_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> (!mem_we && !mem_re));

    // R8
    misaligned_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (misaligned && !mem_re) |=> !load_valid);

    // R3
    load_result_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> load_valid);

    // R9
    no_result_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re |=> !load_valid);

    // R2
    word_store_full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && is_word) |-> (mem_be == {NUM_LANES{1'b1}}));

    // R5
    byte_store_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && is_byte) |-> ($countones(mem_be) == 1));

    // R9
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!mem_we && !mem_re && mem_be == '0));
endmodule

// File: tb/test_lsu_top.sv
module test_lsu_top;
    typedef struct {
        logic [31:0] d;
        int          due;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] base_r = '0;
    logic [15:0] off_r = '0;
    logic [31:0] sd_r = '0;

    logic [31:0] addr_l, addr_b, wdata_l, wdata_b, rdata_l, rdata_b, ld_l, ld_b;
    logic [3:0]  be_l, be_b;
    logic        we_l, we_b, re_l, re_b, lv_l, lv_b, mis_l, mis_b;

    logic [31:0] ram_l [64];
    logic [31:0] ram_b [64];
    logic [31:0] model [2][64];
    exp_t        q_l[$];
    exp_t        q_b[$];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lsu_top #(.BIG_ENDIAN(1'b0)) i_lsu_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .base(base_r), .offset(off_r), .store_data(sd_r),
        .mem_addr(addr_l), .mem_be(be_l), .mem_we(we_l), .mem_re(re_l),
        .mem_wdata(wdata_l), .mem_rdata(rdata_l),
        .load_valid(lv_l), .load_data(ld_l), .misaligned(mis_l)
    );

    lsu_top #(.BIG_ENDIAN(1'b1)) i_lsu_top_big (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .base(base_r), .offset(off_r), .store_data(sd_r),
        .mem_addr(addr_b), .mem_be(be_b), .mem_we(we_b), .mem_re(re_b),
        .mem_wdata(wdata_b), .mem_rdata(rdata_b),
        .load_valid(lv_b), .load_data(ld_b), .misaligned(mis_b)
    );

    function automatic logic [31:0] pattern(input int i);
        return 32'h5AC3_007E ^ (i * 32'h0103_0507);
    endfunction

    // behavioural synchronous-read memories
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) begin
                ram_l[i] <= pattern(i);
                ram_b[i] <= pattern(i);
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                if (we_l && be_l[k]) ram_l[addr_l[7:2]][8*k +: 8] <= wdata_l[8*k +: 8];
                if (we_b && be_b[k]) ram_b[addr_b[7:2]][8*k +: 8] <= wdata_b[8*k +: 8];
            end
            if (re_l) rdata_l <= ram_l[addr_l[7:2]];
            if (re_b) rdata_b <= ram_b[addr_b[7:2]];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: one request, port checks in its cycle, expected results queued
    task automatic issue(input logic [1:0] op, input logic [31:0] base,
                         input logic [15:0] off, input logic [31:0] sd);
        logic [31:0] ea;
        logic [1:0]  lo;
        logic [1:0]  ln;
        logic [5:0]  idx;
        logic [7:0]  bv;
        bit          mis;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        base_r    = base;
        off_r     = off;
        sd_r      = sd;
        #1;
        ea  = base + {{16{off[15]}}, off};
        lo  = ea[1:0];
        idx = ea[7:2];
        mis = (op[1] == 1'b0) && (lo != 2'b00);
        chk("R1 mem_addr little", addr_l, {ea[31:2], 2'b00});
        chk("R1 mem_addr big", addr_b, {ea[31:2], 2'b00});
        chk("R8 misaligned flag little", {31'b0, mis_l}, {31'b0, mis});
        chk("R8 misaligned flag big", {31'b0, mis_b}, {31'b0, mis});
        if (mis) begin
            chk("R8 no access little", {30'b0, we_l, re_l}, 32'd0);
            chk("R8 no access big", {30'b0, we_b, re_b}, 32'd0);
        end else if (op == 2'b01) begin
            chk("R2 word store we/be little", {27'b0, we_l, be_l}, 32'h1F);
            chk("R2 word store we/be big", {27'b0, we_b, be_b}, 32'h1F);
            chk("R2 word store data little", wdata_l, sd);
            chk("R2 word store data big", wdata_b, sd);
            model[0][idx] = sd;
            model[1][idx] = sd;
        end else if (op == 2'b11) begin
            for (int e = 0; e < 2; e++) begin
                ln = (e == 1) ? (2'd3 - lo) : lo;
                chk(e ? "R7 R5 byte store be big" : "R6 R5 byte store be little",
                    {27'b0, e ? we_b : we_l, e ? be_b : be_l}, 32'h10 | (32'd1 << ln));
                chk(e ? "R7 R5 byte store lane data big" : "R6 R5 byte store lane data little",
                    {24'b0, (e ? wdata_b : wdata_l) >> (8 * ln)} & 32'hFF, {24'b0, sd[7:0]});
                model[e][idx][8*ln +: 8] = sd[7:0];
            end
        end else begin
            chk("R3 read strobe little", {31'b0, re_l}, 32'd1);
            chk("R3 read strobe big", {31'b0, re_b}, 32'd1);
            for (int e = 0; e < 2; e++) begin
                exp_t it;
                ln = (e == 1) ? (2'd3 - lo) : lo;
                bv = model[e][idx][8*ln +: 8];
                it.d   = (op == 2'b00) ? model[e][idx] : {{24{bv[7]}}, bv};
                it.due = cyc + 1;
                if (e == 0) q_l.push_back(it);
                else        q_b.push_back(it);
            end
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R9 idle strobes little", {26'b0, we_l, re_l, be_l}, 32'd0);
        chk("R9 idle strobes big", {26'b0, we_b, re_b, be_b}, 32'd0);
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q_l.size() > 0 && q_l[0].due == cyc) begin
                chk("R3 R10 load_valid little", {31'b0, lv_l}, 32'd1);
                chk("R3 R4 R6 load data little", ld_l, q_l[0].d);
                void'(q_l.pop_front());
            end else if (lv_l) begin
                chk("R8 R9 unexpected load_valid little", 32'd1, 32'd0);
            end
            if (q_b.size() > 0 && q_b[0].due == cyc) begin
                chk("R3 R10 load_valid big", {31'b0, lv_b}, 32'd1);
                chk("R3 R4 R7 load data big", ld_b, q_b[0].d);
                void'(q_b.pop_front());
            end else if (lv_b) begin
                chk("R8 R9 unexpected load_valid big", 32'd1, 32'd0);
            end
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            model[0][i] = pattern(i);
            model[1][i] = pattern(i);
        end
        repeat (3) @(negedge clk);
        chk("R9 reset outputs little", {27'b0, lv_l, we_l, re_l, be_l[0], be_l[1]}, 32'd0);
        chk("R9 reset outputs big", {27'b0, lv_b, we_b, re_b, be_b[0], be_b[1]}, 32'd0);
        rst_n = 1'b1;
        idle();

        // word store then word load
        issue(2'b01, 32'h40, 16'h0000, 32'h1122_3344);
        issue(2'b00, 32'h40, 16'h0000, 32'h0);
        idle();

        // byte store with bit 7 set at offset 1, then reload word and bytes
        issue(2'b11, 32'h40, 16'h0001, 32'hFFFF_FF80);
        issue(2'b00, 32'h40, 16'h0000, 32'h0);
        issue(2'b10, 32'h41, 16'h0000, 32'h0);
        issue(2'b10, 32'h40, 16'h0000, 32'h0);
        idle();

        // negative displacement
        issue(2'b01, 32'h84, 16'hFFF8, 32'hCAFE_F00D);
        issue(2'b00, 32'h7C, 16'h0000, 32'h0);
        issue(2'b10, 32'h90, 16'hFFEF, 32'h0);
        idle();

        // misaligned store, then reload the word it must not touch
        issue(2'b01, 32'h40, 16'h0002, 32'hDEAD_BEEF);
        idle();
        issue(2'b00, 32'h40, 16'h0000, 32'h0);
        idle();
        // misaligned load, no result may follow
        issue(2'b00, 32'h41, 16'h0000, 32'h0);
        idle();
        issue(2'b00, 32'h20, 16'h0003, 32'h0);
        idle();

        // R5 byte stores into each lane, then whole word
        for (int b = 0; b < 4; b++) issue(2'b11, 32'h60, 16'(b), 32'h0000_0070 + 32'(b) * 32'h11);
        issue(2'b00, 32'h60, 16'h0000, 32'h0);
        idle();

        // R10 back-to-back byte loads over all offsets of two words
        for (int a = 0; a < 8; a++) issue(2'b10, 32'h30, 16'(a), 32'h0);
        for (int a = 0; a < 4; a++) issue(2'b10, 32'h60, 16'(a), 32'h0);
        idle();
        repeat (3) idle();

        chk("R10 all results returned little", 32'(q_l.size()), 32'd0);
        chk("R10 all results returned big", 32'(q_b.size()), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule